// File: doc/BRIEF.md
# XOR-Reduced Latch Entropy Collector

This block gathers the single-bit outputs of a wide array of free-running bistable entropy cells and turns them into one random bit per sample clock. Each cell is excited by one shared signal that drives both of its inputs. While that signal is low the cell is held high. When it rises, the cell settles to 0 or 1. Any single cell is usually biased, so the block folds the whole array down to one bit with a balanced XOR tree. It captures that bit in one flip-flop and raises a one-cycle valid strobe beside it. No value is ever fed back to the cells. The nominal rate is one bit per cycle of a 2.5 MHz sample clock.

For characterisation, a small command register can route one raw cell to the output instead of the XOR result. The same register holds the run bit. The run bit drives the excitation enable, which gates the cell array's clock so the array can be stopped when no bits are needed. The first sample after the run bit turns on is discarded, because the cells may not have settled yet.

Top module: `latch_entropy_collector`

## Requirements
- R1: After reset, rnd_bit, rnd_valid and excite_en are 0, and the command register is all zero: index 0, XOR source, run off.
- R2: A write with cmd_we high loads cmd_wdata into the command register at the clock edge. The field layout is: bits [7:0] hold the cell index, bit 8 holds the source mode (0 = XOR, 1 = single cell), and bit 9 holds the run bit. The new value takes effect from the next cycle.
- R3: excite_en follows the stored run bit. It is high exactly while run is 1.
- R4: In XOR mode, an accepted sample loads rnd_bit with the parity of all 256 cell_bits present at the sampling edge.
- R5: In single-cell mode, an accepted sample loads rnd_bit with cell_bits[index], where index is the stored cell index.
- R6: rnd_valid is high for exactly the cycle that follows each accepted sample, and low in every other cycle.
- R7: After run turns on, the first cycle with sample_en high is consumed without output: rnd_valid stays low and rnd_bit keeps its value. Every later sample_en cycle, while run stays on, is accepted.
- R8: While run is off, sample_en and cell_bits have no effect: rnd_bit holds its value and rnd_valid stays low. While run is on and sample_en is low, rnd_bit also holds its value.
- R9: Turning run off clears the settle state, so the next turn-on again suppresses its first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cell_bits | input | 256 | Raw outputs of the entropy cells |
| sample_en | input | 1 | Request to capture a sample this cycle |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 10 | Command word: index [7:0], mode [8], run [9] |
| rnd_bit | output | 1 | Registered random or raw-cell bit |
| rnd_valid | output | 1 | One-cycle strobe marking a new rnd_bit |
| excite_en | output | 1 | Clock-gate enable for the cell array |

## Verification
The assertions check several rules on every cycle. In XOR mode the captured bit must equal the parity of the previous cycle's cell vector. In single-cell mode it must equal the indexed raw cell. rnd_bit may only change on an accepted sample. Valid may only follow a run-and-sample cycle, and it must stay low on the first sample after turn-on. Command writes must land in the register. Some behaviours depend on longer histories and only the bench's scenarios can show them. These include the turn-off and re-arm sequence, the edge cases of all-ones and single-one vectors, the extreme indices 0 and 255, and whether sample_en is ignored while the array is stopped.

// File: rtl/lec_pkg.sv
package lec_pkg;
  typedef enum logic {
    SRC_XOR  = 1'b0,
    SRC_CELL = 1'b1
  } src_sel_e;

  // Width of an index able to address n cells (at least 1 bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of halving levels in the reduction tree for n leaves.
  function automatic int tree_levels(input int n);
    return (n > 1) ? $clog2(n) : 0;
  endfunction
endpackage

// File: rtl/lec_cmd_reg.sv
module lec_cmd_reg
  import lec_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int CMD_W = IDX_W + 2,
  localparam int MODE_POS = IDX_W,
  localparam int RUN_POS = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CMD_W-1:0] wdata,
  output logic [IDX_W-1:0] cell_idx,
  output src_sel_e         src_sel,
  output logic             run
);
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (we) begin
      cmd_q <= wdata;
    end
  end

  assign cell_idx = cmd_q[IDX_W-1:0];
  assign src_sel  = src_sel_e'(cmd_q[MODE_POS]);
  assign run      = cmd_q[RUN_POS];
endmodule

// File: rtl/lec_xor_tree.sv
module lec_xor_tree
  import lec_pkg::*;
#(
  parameter int NUM_CELLS = 256,
  localparam int LEVELS = tree_levels(NUM_CELLS),
  localparam int PADDED = 1 << LEVELS
) (
  input  logic [NUM_CELLS-1:0] cells,
  output logic                 parity
);
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    logic [(PADDED >> l)-1:0] v;
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < PADDED; j++) begin : g_in
        if (j < NUM_CELLS) begin : g_real
          assign v[j] = cells[j];
        end else begin : g_pad
          assign v[j] = 1'b0;
        end
      end
    end else begin : g_node
      for (genvar k = 0; k < (PADDED >> l); k++) begin : g_pair
        assign v[k] = g_lvl[l-1].v[2*k] ^ g_lvl[l-1].v[2*k+1];
      end
    end
  end

  assign parity = g_lvl[LEVELS].v[0];
endmodule

// File: rtl/lec_cell_mux.sv
module lec_cell_mux
  import lec_pkg::*;
#(
  parameter int NUM_CELLS = 256,
  localparam int IDX_W = idx_width(NUM_CELLS),
  localparam int SPAN = 1 << IDX_W
) (
  input  logic [NUM_CELLS-1:0] cells,
  input  logic [IDX_W-1:0]     cell_idx,
  input  logic                 xor_bit,
  input  src_sel_e             src_sel,
  output logic                 raw_bit,
  output logic                 out_bit
);
  logic [SPAN-1:0] padded;

  if (SPAN == NUM_CELLS) begin : g_exact
    assign padded = cells;
  end else begin : g_pad
    assign padded = {{(SPAN-NUM_CELLS){1'b0}}, cells};
  end

  // Wide selector: one raw cell by index.
  assign raw_bit = padded[cell_idx];

  // Narrow selector: folded result or the raw cell.
  always_comb begin
    unique case (src_sel)
      SRC_CELL: out_bit = raw_bit;
      default:  out_bit = xor_bit;
    endcase
  end
endmodule

// File: rtl/lec_capture.sv
module lec_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sample_en,
  input  logic src_bit,
  output logic rnd_bit,
  output logic rnd_valid,
  output logic armed,
  output logic take_sample,
  output logic drop_sample
);
  logic armed_q;
  logic bit_q;
  logic valid_q;

  assign take_sample = run && sample_en && armed_q;
  assign drop_sample = run && sample_en && !armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take_sample;
      if (take_sample) begin
        bit_q <= src_bit;
      end
      if (!run) begin
        armed_q <= 1'b0;
      end else if (drop_sample) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign rnd_bit   = bit_q;
  assign rnd_valid = valid_q;
  assign armed     = armed_q;
endmodule

// File: rtl/latch_entropy_collector.sv
module latch_entropy_collector
  import lec_pkg::*;
#(
  parameter int NUM_CELLS = 256,
  localparam int IDX_W = idx_width(NUM_CELLS),
  localparam int CMD_W = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CELLS-1:0] cell_bits,
  input  logic                 sample_en,
  input  logic                 cmd_we,
  input  logic [CMD_W-1:0]     cmd_wdata,
  output logic                 rnd_bit,
  output logic                 rnd_valid,
  output logic                 excite_en
);
  logic [IDX_W-1:0] cmd_idx;
  src_sel_e         cmd_src;
  logic             cmd_run;
  logic             fold_bit;
  logic             raw_bit;
  logic             sel_bit;
  logic             armed;
  logic             take_sample;
  logic             drop_sample;

  lec_cmd_reg #(.IDX_W(IDX_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cmd_we),
    .wdata    (cmd_wdata),
    .cell_idx (cmd_idx),
    .src_sel  (cmd_src),
    .run      (cmd_run)
  );

  lec_xor_tree #(.NUM_CELLS(NUM_CELLS)) u_tree (
    .cells  (cell_bits),
    .parity (fold_bit)
  );

  lec_cell_mux #(.NUM_CELLS(NUM_CELLS)) u_mux (
    .cells    (cell_bits),
    .cell_idx (cmd_idx),
    .xor_bit  (fold_bit),
    .src_sel  (cmd_src),
    .raw_bit  (raw_bit),
    .out_bit  (sel_bit)
  );

  lec_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (cmd_run),
    .sample_en   (sample_en),
    .src_bit     (sel_bit),
    .rnd_bit     (rnd_bit),
    .rnd_valid   (rnd_valid),
    .armed       (armed),
    .take_sample (take_sample),
    .drop_sample (drop_sample)
  );

  assign excite_en = cmd_run;
endmodule

// File: rtl/lec_checker.sv
module lec_checker
  import lec_pkg::*;
#(
  parameter int NUM_CELLS = 256,
  localparam int IDX_W = idx_width(NUM_CELLS),
  localparam int CMD_W = IDX_W + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CELLS-1:0] cell_bits,
  input logic                 sample_en,
  input logic                 cmd_we,
  input logic [CMD_W-1:0]     cmd_wdata,
  input logic                 rnd_bit,
  input logic                 rnd_valid,
  input logic                 excite_en,
  input logic [IDX_W-1:0]     cmd_idx,
  input src_sel_e             cmd_src,
  input logic                 armed
);
  a_r2_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (cmd_idx == $past(cmd_wdata[IDX_W-1:0]))
               && (excite_en == $past(cmd_wdata[IDX_W+1])));

  a_r4_xor_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (excite_en && sample_en && armed && cmd_src == SRC_XOR)
      |=> (rnd_bit == $past(^cell_bits)));

  a_r5_raw_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (excite_en && sample_en && armed && cmd_src == SRC_CELL)
      |=> (rnd_bit == $past(cell_bits[cmd_idx])));

  a_r6_valid_origin: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |-> $past(excite_en && sample_en));

  a_r7_first_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (excite_en && sample_en && !armed) |=> (!rnd_valid && $stable(rnd_bit)));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(excite_en && sample_en) |=> (!rnd_valid && $stable(rnd_bit)));

  a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    !excite_en |=> !armed);
endmodule

bind latch_entropy_collector lec_checker #(.NUM_CELLS(NUM_CELLS)) u_lec_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cell_bits (cell_bits),
  .sample_en (sample_en),
  .cmd_we    (cmd_we),
  .cmd_wdata (cmd_wdata),
  .rnd_bit   (rnd_bit),
  .rnd_valid (rnd_valid),
  .excite_en (excite_en),
  .cmd_idx   (cmd_idx),
  .cmd_src   (cmd_src),
  .armed     (armed)
);

// File: tb/latch_entropy_collector_test.sv
`timescale 1ns/1ps
module latch_entropy_collector_test;
  localparam int N = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  cell_bits = '0;
  logic          sample_en = 1'b0;
  logic          cmd_we = 1'b0;
  logic [9:0]    cmd_wdata = '0;
  logic          rnd_bit;
  logic          rnd_valid;
  logic          excite_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of the command fields and capture state
  logic [7:0] m_idx = '0;
  logic       m_mode = 1'b0;
  logic       m_run = 1'b0;
  logic       m_armed = 1'b0;
  logic       m_bit = 1'b0;
  logic       m_valid = 1'b0;

  latch_entropy_collector uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_bits (cell_bits),
    .sample_en (sample_en),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .rnd_bit   (rnd_bit),
    .rnd_valid (rnd_valid),
    .excite_en (excite_en)
  );

  always #2.5 clk = ~clk;

  function automatic logic count_parity(input logic [N-1:0] v);
    int ones = 0;
    for (int i = 0; i < N; i++) if (v[i]) ones++;
    return logic'(ones % 2);
  endfunction

  function automatic logic [N-1:0] rand_cells();
    logic [N-1:0] v;
    for (int w = 0; w < N / 32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, update model at the edge, compare after it
  task automatic tick(input logic we, input logic [9:0] wd,
                      input logic [N-1:0] cells, input logic sen,
                      input string tag);
    @(negedge clk);
    cmd_we = we; cmd_wdata = wd; cell_bits = cells; sample_en = sen;
    @(posedge clk);
    if (m_run && sen && m_armed) begin
      m_bit   = m_mode ? cells[m_idx] : count_parity(cells);
      m_valid = 1'b1;
    end else begin
      m_valid = 1'b0;
    end
    if (!m_run) m_armed = 1'b0;
    else if (sen) m_armed = 1'b1;
    if (we) begin
      m_idx = wd[7:0]; m_mode = wd[8]; m_run = wd[9];
    end
    #1;
    check({tag, " rnd_bit"}, rnd_bit, m_bit);
    check({tag, " rnd_valid"}, rnd_valid, m_valid);
    check("R3 excite_en", excite_en, m_run);
  endtask

  function automatic logic [9:0] cmd(input logic run, input logic mode,
                                     input logic [7:0] idx);
    return {run, mode, idx};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 rnd_bit", rnd_bit, 1'b0);
    check("R1 rnd_valid", rnd_valid, 1'b0);
    check("R1 excite_en", excite_en, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R8: run off, sampling ignored
    for (int i = 0; i < 4; i++) tick(1'b0, '0, '1 ^ (N'(1) << i), 1'b1, "R8 idle");

    // R2/R7: enable run in XOR mode; first sample dropped
    tick(1'b1, cmd(1'b1, 1'b0, 8'd0), '0, 1'b0, "R2 write");
    tick(1'b0, '0, N'(1), 1'b1, "R7 first");
    // R4: single one -> 1, all ones -> 0
    tick(1'b0, '0, N'(1) << 200, 1'b1, "R4 single one");
    tick(1'b0, '0, '1, 1'b1, "R4 all ones");
    tick(1'b0, '0, N'(3), 1'b1, "R4 two ones");
    // R8: sample_en low holds
    tick(1'b0, '0, N'(1), 1'b0, "R8 hold");

    // R5: single-cell mode at extreme indices
    tick(1'b1, cmd(1'b1, 1'b1, 8'd255), '0, 1'b0, "R2 write");
    tick(1'b0, '0, N'(1) << 255, 1'b1, "R5 idx255");
    tick(1'b0, '0, ~(N'(1) << 255), 1'b1, "R5 idx255 zero");
    tick(1'b1, cmd(1'b1, 1'b1, 8'd0), '0, 1'b0, "R2 write");
    tick(1'b0, '0, N'(1), 1'b1, "R5 idx0");

    // R9: run off then on again: first sample dropped once more
    tick(1'b1, cmd(1'b0, 1'b0, 8'd0), '0, 1'b1, "R9 off");
    tick(1'b0, '0, '1, 1'b1, "R8 off sample");
    tick(1'b1, cmd(1'b1, 1'b0, 8'd0), '0, 1'b0, "R9 on");
    tick(1'b0, '0, N'(1), 1'b1, "R9 first again");
    tick(1'b0, '0, N'(1), 1'b1, "R6 after rearm");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic we;
      logic [9:0] wd;
      we = ($urandom % 16) == 0;
      wd = {($urandom % 8) != 0 ? 1'b1 : 1'b0, 1'($urandom), 8'($urandom)};
      tick(we, wd, rand_cells(), 1'($urandom % 4 != 0), "R4/R5/R6 random");
    end

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule